// File: doc/BRIEF.md
# Lock Level Ordering Checker

This block enforces a deadlock-free acquisition order on a set of shared locks. Every lock is given a level from 0 to 15. A requester that needs several locks must take them in strictly rising level order. Two requesters therefore can never each hold one lock while spinning on the one the other holds. The block keeps a 16-bit bitmap of held levels for every requester. It judges each acquire or release request against that requester's own bitmap and answers one cycle later with a grant or an error.

A request names a requester, a level, an operation (acquire or release) and a mode. A wait-mode acquire is refused when the requester already holds the requested level or any level above it. A no-wait acquire cannot deadlock, so it is always accepted and recorded. Releasing a level that is not held is reported as its own kind of error. Both kinds of error also set a sticky fault flag, which stays set until software clears it.

The block does not store the locks themselves and does not arbitrate between requesters. A small query port shows the bitmap of any requester.

Top module: `lock_order_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears every bitmap, both sticky fault flags and all response outputs.
- R2: `resp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. When `resp_valid` is low, `resp_grant`, `resp_order_err` and `resp_rel_err` are 0.
- R3: A wait-mode acquire (`req_acq`=1, `req_nowait`=0) is refused when the requester holds its requested level or any higher level. The response is `resp_order_err`=1 and `resp_grant`=0, and the bitmap does not change.
- R4: A wait-mode acquire is granted when every level the requester holds is strictly below the requested one, including when it holds nothing. The grant sets bit `req_level` of that requester's bitmap.
- R5: A no-wait acquire (`req_acq`=1, `req_nowait`=1) is always granted, whatever levels are held, and sets bit `req_level`.
- R6: A release (`req_acq`=0) of a level that is held is granted and clears that bit only.
- R7: A release of a level that is not held gives `resp_rel_err`=1 and `resp_grant`=0, and leaves the bitmap unchanged.
- R8: Requesters are independent. A request is judged only against its own requester's bitmap and changes no other requester's bitmap.
- R9: `order_fault` is set by an R3 refusal and `release_fault` by an R7 error. Each stays set until a cycle with `err_clr`=1. When an error and `err_clr` arrive in the same cycle, the error wins.
- R10: `qry_map` shows, without delay, the bitmap of requester `qry_id`, with bit i standing for level i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_acq | input | 1 | 1 = acquire, 0 = release |
| req_id | input | ID_W (2) | Requester index |
| req_level | input | LVL_W (4) | Lock level of the request |
| req_nowait | input | 1 | 1 = no-wait acquire (skips the order check) |
| err_clr | input | 1 | Clears both sticky fault flags |
| qry_id | input | ID_W (2) | Requester whose bitmap is shown on qry_map |
| qry_map | output | 2**LVL_W (16) | Held-level bitmap of qry_id |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_grant | output | 1 | Request accepted |
| resp_order_err | output | 1 | Wait-mode acquire broke the ascending order |
| resp_rel_err | output | 1 | Release of a level that was not held |
| order_fault | output | 1 | Sticky flag for ordering errors |
| release_fault | output | 1 | Sticky flag for release errors |

## Verification
The bench checks the edges of the comparison: re-acquiring the same level, acquiring below a held level, and levels 0 and 15. A design whose mask started one bit too high would grant a same-level acquire, and one that ignored bit 15 would let a requester holding 15 take anything. It also checks that a no-wait acquire is granted even when an order violation is present, and that releasing an unheld level leaves the map alone. It confirms that one requester's holdings never block another requester. Finally, it pulses `err_clr` in the same cycle as a fresh violation, where a design that gave clear the priority would lose the fault.

// File: rtl/lock_order_pkg.sv
// Package: shared operation encoding and verdict record of the lock ordering checker.
// Assumes: nothing; types only.
package lock_order_pkg;

    // Request operation as carried on req_acq.
    typedef enum logic {
        OP_RELEASE = 1'b0,
        OP_ACQUIRE = 1'b1
    } lock_op_e;

    // Outcome of judging one request.
    typedef struct packed {
        logic grant;
        logic order_err;
        logic rel_err;
    } verdict_t;

    localparam verdict_t VERDICT_NONE = '{grant: 1'b0, order_err: 1'b0, rel_err: 1'b0};

endpackage

// File: rtl/lvl_mask_gen.sv
// Module: builds the "at or above" mask of a level (bit g set when g >= level)
// and the one-hot mask of the level itself.
// Assumes: LEVELS equals 2**LVL_W so every level value names a real bit.
module lvl_mask_gen #(
    parameter int LVL_W  = 4,
    parameter int LEVELS = 1 << LVL_W
) (
    input  logic [LVL_W-1:0]  level,
    output logic [LEVELS-1:0] ge_mask,
    output logic [LEVELS-1:0] hit_mask
);

    // One comparator per level position.
    for (genvar g = 0; g < LEVELS; g++) begin : g_bit
        assign ge_mask[g]  = (level <= LVL_W'(g));
        assign hit_mask[g] = (level == LVL_W'(g));
    end

endmodule

// File: rtl/holder_bank.sv
// Module: held-level bitmap storage, one register per requester, with a
// request-side read port, a query read port and a single write port.
// Assumes: ids below N_REQ; synchronous active-low reset clears all maps.
module holder_bank #(
    parameter int N_REQ  = 4,
    parameter int LEVELS = 16,
    parameter int ID_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ID_W-1:0]          wr_id,
    input  logic [LEVELS-1:0]        wr_map,
    input  logic [ID_W-1:0]          rd_id,
    output logic [LEVELS-1:0]        rd_map,
    input  logic [ID_W-1:0]          qry_id,
    output logic [LEVELS-1:0]        qry_map,
    output logic [N_REQ*LEVELS-1:0]  all_maps
);

    logic [LEVELS-1:0] map_q [N_REQ];

    for (genvar r = 0; r < N_REQ; r++) begin : g_req
        // Holds one requester's bitmap; loads it when the write targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[r] <= '0;
            end else if (wr_en && (wr_id == ID_W'(r))) begin
                map_q[r] <= wr_map;
            end
        end
        assign all_maps[r*LEVELS +: LEVELS] = map_q[r];
    end

    // Selects the bitmap of the requester being judged.
    always_comb begin
        rd_map = '0;
        for (int r = 0; r < N_REQ; r++) begin
            if (rd_id == ID_W'(r)) rd_map = map_q[r];
        end
    end

    // Selects the bitmap shown on the query port.
    always_comb begin
        qry_map = '0;
        for (int r = 0; r < N_REQ; r++) begin
            if (qry_id == ID_W'(r)) qry_map = map_q[r];
        end
    end

endmodule

// File: rtl/order_judge.sv
// Module: combinational verdict for one request against its requester's map,
// plus the map to be written back.
// Assumes: ge_mask/hit_mask come from lvl_mask_gen for the same level.
module order_judge
    import lock_order_pkg::*;
#(
    parameter int LEVELS = 16
) (
    input  logic              req_valid,
    input  lock_op_e          req_op,
    input  logic              req_nowait,
    input  logic [LEVELS-1:0] cur_map,
    input  logic [LEVELS-1:0] ge_mask,
    input  logic [LEVELS-1:0] hit_mask,
    output verdict_t          verdict,
    output logic              map_wr,
    output logic [LEVELS-1:0] next_map
);

    logic conflict;
    logic is_held;

    // Any held level at or above the request breaks ascending order.
    assign conflict = |(cur_map & ge_mask);
    assign is_held  = |(cur_map & hit_mask);

    // Decides grant or error and forms the updated bitmap.
    always_comb begin
        verdict  = VERDICT_NONE;
        map_wr   = 1'b0;
        next_map = cur_map;
        if (req_valid) begin
            if (req_op == OP_ACQUIRE) begin
                if (conflict && !req_nowait) begin
                    verdict.order_err = 1'b1;
                end else begin
                    verdict.grant = 1'b1;
                    map_wr        = 1'b1;
                    next_map      = cur_map | hit_mask;
                end
            end else begin
                if (is_held) begin
                    verdict.grant = 1'b1;
                    map_wr        = 1'b1;
                    next_map      = cur_map & ~hit_mask;
                end else begin
                    verdict.rel_err = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/err_sticky.sv
// Module: two sticky fault flags; a set in the same cycle as a clear wins.
// Assumes: synchronous active-low reset.
module err_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_order,
    input  logic set_rel,
    input  logic clr,
    output logic order_fault,
    output logic release_fault
);

    // Keeps the ordering fault until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)         order_fault <= 1'b0;
        else if (set_order) order_fault <= 1'b1;
        else if (clr)       order_fault <= 1'b0;
    end

    // Keeps the release fault until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)       release_fault <= 1'b0;
        else if (set_rel) release_fault <= 1'b1;
        else if (clr)     release_fault <= 1'b0;
    end

endmodule

// File: rtl/lock_order_guard.sv
// Module: top of the lock level ordering checker. Judges acquire/release
// requests against per-requester held-level bitmaps and answers one cycle later.
// Assumes: at most one request per cycle; req_id and qry_id below N_REQ;
// synchronous active-low reset.
module lock_order_guard
    import lock_order_pkg::*;
#(
    parameter int N_REQ = 4,
    parameter int LVL_W = 4,
    localparam int ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int LEVELS = 1 << LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_acq,
    input  logic [ID_W-1:0]   req_id,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              req_nowait,
    input  logic              err_clr,
    input  logic [ID_W-1:0]   qry_id,
    output logic [LEVELS-1:0] qry_map,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              resp_order_err,
    output logic              resp_rel_err,
    output logic              order_fault,
    output logic              release_fault
);

    logic [LEVELS-1:0]       ge_mask;
    logic [LEVELS-1:0]       hit_mask;
    logic [LEVELS-1:0]       cur_map;
    logic [LEVELS-1:0]       next_map;
    logic                    map_wr;
    verdict_t                verdict;
    logic [N_REQ*LEVELS-1:0] held_flat;
    lock_op_e                req_op;

    assign req_op = lock_op_e'(req_acq);

    lvl_mask_gen #(.LVL_W(LVL_W), .LEVELS(LEVELS)) u_mask (
        .level    (req_level),
        .ge_mask  (ge_mask),
        .hit_mask (hit_mask)
    );

    holder_bank #(.N_REQ(N_REQ), .LEVELS(LEVELS), .ID_W(ID_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_wr),
        .wr_id    (req_id),
        .wr_map   (next_map),
        .rd_id    (req_id),
        .rd_map   (cur_map),
        .qry_id   (qry_id),
        .qry_map  (qry_map),
        .all_maps (held_flat)
    );

    order_judge #(.LEVELS(LEVELS)) u_judge (
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_nowait (req_nowait),
        .cur_map    (cur_map),
        .ge_mask    (ge_mask),
        .hit_mask   (hit_mask),
        .verdict    (verdict),
        .map_wr     (map_wr),
        .next_map   (next_map)
    );

    err_sticky u_sticky (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_order     (verdict.order_err),
        .set_rel       (verdict.rel_err),
        .clr           (err_clr),
        .order_fault   (order_fault),
        .release_fault (release_fault)
    );

    // Registers the verdict so every request is answered in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_grant     <= 1'b0;
            resp_order_err <= 1'b0;
            resp_rel_err   <= 1'b0;
        end else begin
            resp_valid     <= req_valid;
            resp_grant     <= verdict.grant;
            resp_order_err <= verdict.order_err;
            resp_rel_err   <= verdict.rel_err;
        end
    end

endmodule

// File: rtl/lock_order_guard_chk.sv
// Checker: temporal properties of lock_order_guard, bound into every instance.
// Assumes: the bound instance is reset low at the first clock edge.
module lock_order_guard_chk #(
    parameter int N_REQ  = 4,
    parameter int LVL_W  = 4,
    parameter int ID_W   = 2,
    parameter int LEVELS = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_acq,
    input logic [ID_W-1:0]         req_id,
    input logic [LVL_W-1:0]        req_level,
    input logic                    req_nowait,
    input logic                    err_clr,
    input logic                    resp_valid,
    input logic                    resp_grant,
    input logic                    resp_order_err,
    input logic                    resp_rel_err,
    input logic                    order_fault,
    input logic                    release_fault,
    input logic [N_REQ*LEVELS-1:0] held_flat
);

    logic [LEVELS-1:0]     own_map;
    logic [ID_W-1:0]       last_id;
    logic [LVL_W-1:0]      last_lvl;
    logic                  last_acq;
    logic                  last_bit;

    // Bitmap of the requester currently asking.
    always_comb begin
        own_map = '0;
        for (int r = 0; r < N_REQ; r++) begin
            if (req_id == ID_W'(r)) own_map = held_flat[r*LEVELS +: LEVELS];
        end
    end

    // Remembers the previous request for post-update checks.
    always_ff @(posedge clk) begin
        last_id  <= req_id;
        last_lvl <= req_level;
        last_acq <= req_acq;
    end

    // Bit of the previous request's level in the current bitmaps.
    always_comb begin
        last_bit = 1'b0;
        for (int r = 0; r < N_REQ; r++) begin
            for (int l = 0; l < LEVELS; l++) begin
                if (last_id == ID_W'(r) && last_lvl == LVL_W'(l))
                    last_bit = held_flat[r*LEVELS + l];
            end
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (held_flat == '0) && !resp_valid && !order_fault && !release_fault);

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_grant && !resp_order_err && !resp_rel_err);

    p_refuse_high_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_acq && !req_nowait && ((own_map >> req_level) != '0)
        |=> resp_order_err && !resp_grant && $stable(held_flat));

    p_nowait_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_acq && req_nowait |=> resp_grant && !resp_order_err);

    p_acquire_sets_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_grant && last_acq |-> last_bit);

    p_release_clears_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_grant && !last_acq |-> !last_bit);

    p_bad_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_acq && !own_map[req_level]
        |=> resp_rel_err && !resp_grant && $stable(held_flat));

    p_order_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        order_fault && !err_clr |=> order_fault);

    p_release_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        release_fault && !err_clr |=> release_fault);

endmodule

bind lock_order_guard lock_order_guard_chk #(
    .N_REQ(N_REQ), .LVL_W(LVL_W), .ID_W(ID_W), .LEVELS(LEVELS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_acq        (req_acq),
    .req_id         (req_id),
    .req_level      (req_level),
    .req_nowait     (req_nowait),
    .err_clr        (err_clr),
    .resp_valid     (resp_valid),
    .resp_grant     (resp_grant),
    .resp_order_err (resp_order_err),
    .resp_rel_err   (resp_rel_err),
    .order_fault    (order_fault),
    .release_fault  (release_fault),
    .held_flat      (held_flat)
);

// File: tb/sim_lock_order_guard.sv
// Bench: directed scenarios for lock_order_guard, checked against a bench model.
`timescale 1ns/1ps
module sim_lock_order_guard;

    localparam int  N_REQ = 4;
    localparam real CYC   = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_acq = 1'b0;
    logic [1:0]  req_id = '0;
    logic [3:0]  req_level = '0;
    logic        req_nowait = 1'b0;
    logic        err_clr = 1'b0;
    logic [1:0]  qry_id = '0;
    logic [15:0] qry_map;
    logic        resp_valid, resp_grant, resp_order_err, resp_rel_err;
    logic        order_fault, release_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] mdl [N_REQ];
    bit          so_exp = 1'b0;
    bit          sr_exp = 1'b0;

    always #(CYC/2) clk = ~clk;

    lock_order_guard #(.N_REQ(N_REQ), .LVL_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acq(req_acq),
        .req_id(req_id), .req_level(req_level), .req_nowait(req_nowait),
        .err_clr(err_clr), .qry_id(qry_id), .qry_map(qry_map),
        .resp_valid(resp_valid), .resp_grant(resp_grant),
        .resp_order_err(resp_order_err), .resp_rel_err(resp_rel_err),
        .order_fault(order_fault), .release_fault(release_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Issues one request, updates the model and checks the response.
    task automatic issue(input int id, input bit acq, input int lvl, input bit nw,
                         input string tag, input bit clr = 1'b0);
        bit conflict = 1'b0, grant, rel_err = 1'b0;
        if (acq) begin
            conflict = !nw && ((mdl[id] >> lvl) != 16'h0);
            grant    = !conflict;
            if (grant) mdl[id][lvl] = 1'b1;
        end else begin
            grant   = mdl[id][lvl];
            rel_err = !grant;
            if (grant) mdl[id][lvl] = 1'b0;
        end
        so_exp = conflict ? 1'b1 : (clr ? 1'b0 : so_exp);
        sr_exp = rel_err  ? 1'b1 : (clr ? 1'b0 : sr_exp);
        @(negedge clk);
        req_valid = 1'b1; req_acq = acq; req_id = 2'(id); req_level = 4'(lvl);
        req_nowait = nw; err_clr = clr; qry_id = 2'(id);
        @(negedge clk);
        req_valid = 1'b0; err_clr = 1'b0;
        chk({tag, " R2 resp_valid"}, 32'(resp_valid), 32'd1);
        chk({tag, " grant"},         32'(resp_grant), 32'(grant));
        chk({tag, " order_err"},     32'(resp_order_err), 32'(conflict));
        chk({tag, " rel_err"},       32'(resp_rel_err), 32'(rel_err));
        chk({tag, " R10 map"},       32'(qry_map), 32'(mdl[id]));
        chk({tag, " R9 order_fault"},   32'(order_fault), 32'(so_exp));
        chk({tag, " R9 release_fault"}, 32'(release_fault), 32'(sr_exp));
    endtask

    task automatic check_all_maps(input string tag);
        for (int r = 0; r < N_REQ; r++) begin
            qry_id = 2'(r);
            #1;
            chk(tag, 32'(qry_map), 32'(mdl[r]));
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < N_REQ; r++) mdl[r] = '0;
        so_exp = 1'b0; sr_exp = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_all_maps("R1 map after reset");
        chk("R1 resp_valid", 32'(resp_valid), 32'd0);
        chk("R1 order_fault", 32'(order_fault), 32'd0);
        chk("R1 release_fault", 32'(release_fault), 32'd0);
    endtask

    task automatic t_ascending();
        issue(0, 1, 2, 0, "R4 asc");
        issue(0, 1, 5, 0, "R4 asc");
        issue(0, 1, 9, 0, "R4 asc");
        issue(0, 1, 15, 0, "R4 top level");
        issue(1, 1, 0, 0, "R4 level zero");
        issue(1, 1, 1, 0, "R4 asc");
        @(negedge clk);
        chk("R2 idle resp_valid", 32'(resp_valid), 32'd0);
        chk("R2 idle grant", 32'(resp_grant), 32'd0);
    endtask

    task automatic t_order();
        issue(0, 1, 15, 0, "R3 same top");
        issue(0, 1, 3, 0, "R3 below held");
        issue(2, 1, 7, 0, "R4 first");
        issue(2, 1, 7, 0, "R3 same level");
        issue(2, 1, 4, 0, "R3 lower");
        issue(2, 1, 8, 0, "R4 next up");
        issue(1, 1, 0, 0, "R3 level zero re-take");
    endtask

    task automatic t_nowait();
        issue(0, 1, 3, 1, "R5 nowait below held");
        issue(0, 1, 0, 1, "R5 nowait level zero");
        issue(2, 1, 8, 1, "R5 nowait held level");
    endtask

    task automatic t_release();
        issue(0, 0, 15, 0, "R6 rel");
        issue(0, 0, 9, 0, "R6 rel");
        issue(0, 0, 5, 0, "R6 rel");
        issue(0, 0, 3, 0, "R6 rel");
        issue(0, 1, 4, 0, "R4 after release");
    endtask

    task automatic t_rel_unheld();
        issue(0, 0, 12, 0, "R7 unheld");
        issue(3, 0, 0, 0, "R7 empty map");
        issue(3, 0, 15, 0, "R7 empty top");
    endtask

    task automatic t_indep();
        issue(3, 1, 0, 0, "R8 other holds zero");
        issue(3, 1, 1, 0, "R8 other holds one");
        check_all_maps("R8 maps unchanged");
    endtask

    task automatic t_sticky();
        repeat (3) @(negedge clk);
        chk("R9 order kept idle", 32'(order_fault), 32'(so_exp));
        chk("R9 release kept idle", 32'(release_fault), 32'(sr_exp));
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        so_exp = 1'b0; sr_exp = 1'b0;
        chk("R9 order cleared", 32'(order_fault), 32'd0);
        chk("R9 release cleared", 32'(release_fault), 32'd0);
        chk("R2 no resp on clear", 32'(resp_valid), 32'd0);
        issue(3, 1, 1, 0, "R9 set beats clear", 1'b1);
        issue(3, 0, 9, 0, "R9 rel set beats clear", 1'b1);
        issue(3, 1, 5, 0, "R9 clear on good request", 1'b1);
    endtask

    initial begin
        for (int r = 0; r < N_REQ; r++) mdl[r] = '0;
        repeat (2) @(negedge clk);
        t_reset();
        t_ascending();
        t_order();
        t_nowait();
        t_release();
        t_rel_unheld();
        t_indep();
        t_sticky();
        t_reset();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CYC * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule